// File: doc/BRIEF.md
# Command-Transport Test Access Port

This block is a test access port controller that carries memory-mapped commands from a serial debug link to a bus-side controller. It runs entirely on the test clock `tck`. The `tms` input steers the standard sixteen-state TAP state machine, and `arst` forces that machine asynchronously into Test-Logic-Reset. An 8-bit instruction is shifted in from `tdi` through the instruction path, and a 32-bit operand is shifted in afterwards through the data path. Both committed values appear without interruption on the parallel outputs `cmd_code` and `cmd_data`, where a bus-side controller decodes them.

Return traffic uses a two-wire handshake. The bus side places a word on `rd_word` and raises `rd_valid`. The block latches the word on a `tck` rising edge and acknowledges it on `rd_taken`. The next Capture-DR loads the latched word into the data shift register, and the following Shift-DR moves it out on `tdo_bit`. The serial output has a companion flag, `tdo_drv`, which is high only while `tdo_bit` carries shift data. Both outputs change on the falling edge of `tck`.

The state machine has these states: Test-Logic-Reset, Run-Test/Idle, Select-DR-Scan, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR-Scan, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR. With `tms` high it moves as follows:
- Test-Logic-Reset stays in Test-Logic-Reset.
- Run-Test/Idle and both Update states go to Select-DR-Scan.
- Select-DR-Scan goes to Select-IR-Scan.
- Select-IR-Scan goes to Test-Logic-Reset.
- Capture and Shift go to Exit1, in either path.
- Exit1 and Exit2 go to Update, in either path.
- Pause goes to Exit2, in either path.

With `tms` low it moves as follows:
- Test-Logic-Reset, Run-Test/Idle and both Update states go to Run-Test/Idle.
- Each Select state goes to the Capture state of its own path.
- Capture, Shift and Exit2 go to Shift, in either path.
- Exit1 and Pause go to Pause, in either path.

Top module: `jtc_cmd_tap`

## Requirements
- R1: While `arst` is high the state machine is held in Test-Logic-Reset, and `tdo_bit`, `tdo_drv`, `rd_taken`, `cmd_code`, `cmd_data` and the latched read-back word are all zero.
- R2: Every rising edge of `tck` taken in Test-Logic-Reset sets `cmd_code` to 0x00 and leaves `cmd_data` unchanged. Six edges with `tms` high reach this state from any state.
- R3: Capture-IR loads 0x01 into the 8-bit instruction shift register. Each Shift-IR edge shifts `tdi` in at bit 7 and moves bit 0 out first. `cmd_code` takes the shifted value only on the edge taken in Update-IR.
- R4: Capture-DR loads the latched read-back word into the 32-bit data shift register. Each Shift-DR edge shifts `tdi` in at bit 31 and moves bit 0 out first. `cmd_data` takes the shifted value only on the edge taken in Update-DR.
- R5: In Pause-DR the data shift register holds its contents. After a return through Exit2-DR to Shift-DR, shifting resumes at the next bit.
- R6: On each falling edge of `tck`, `tdo_drv` becomes 1 exactly when the state is Shift-IR or Shift-DR. `tdo_bit` becomes bit 0 of the active shift register, or 0 in any other state. Neither output changes on a rising edge.
- R7: A rising edge that sees `rd_valid` high while `rd_taken` is low latches `rd_word` and sets `rd_taken`. `rd_taken` stays high while `rd_valid` stays high, and it clears on the first rising edge that sees `rd_valid` low.
- R8: When the read-back latch edge and the Capture-DR edge are the same edge, the capture takes the previously latched word, and the newly latched word appears at the next Capture-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, the only clock of the block |
| tms | input | 1 | Mode select that steers the state machine |
| tdi | input | 1 | Serial data in |
| arst | input | 1 | Asynchronous reset, active high |
| tdo_bit | output | 1 | Serial data out, updated on the falling edge |
| tdo_drv | output | 1 | High while `tdo_bit` carries shift data |
| cmd_code | output | 8 | Committed instruction value |
| cmd_data | output | 32 | Committed data value |
| rd_word | input | 32 | Read-back word from the bus side |
| rd_valid | input | 1 | Read-back word is present |
| rd_taken | output | 1 | Read-back word has been latched |

## Verification
Latching a new read-back word and capturing the data register can both fall on the same rising edge of `tck`. The bench provokes this by raising `rd_valid` with a fresh word in the half cycle just before the Capture-DR edge. The scoreboard must then see the previously latched word come out on `tdo_bit`, and the fresh word must come out on the following scan. A Pause-DR in the middle of a scan is also checked: the scan is split into two 16-bit segments, and the scoreboard compares each against its half of the captured word.

// File: rtl/jtc_pkg.sv
package jtc_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PAU_DR  = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PAU_IR  = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_st_e;

endpackage

// File: rtl/jtc_tap_fsm.sv
module jtc_tap_fsm
    import jtc_pkg::*;
(
    input  logic    tck,
    input  logic    arst,
    input  logic    tms,
    output tap_st_e st,
    output logic    in_reset,
    output logic    cap_ir,
    output logic    sh_ir,
    output logic    upd_ir,
    output logic    cap_dr,
    output logic    sh_dr,
    output logic    upd_dr
);

    tap_st_e nxt;

    // State register
    always_ff @(posedge tck or posedge arst) begin
        if (arst) st <= ST_RESET;
        else      st <= nxt;
    end

    // Transition decode
    always_comb begin
        unique case (st)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // Output decode
    always_comb begin
        in_reset = 1'b0;
        cap_ir   = 1'b0;
        sh_ir    = 1'b0;
        upd_ir   = 1'b0;
        cap_dr   = 1'b0;
        sh_dr    = 1'b0;
        upd_dr   = 1'b0;
        unique case (st)
            ST_RESET:  in_reset = 1'b1;
            ST_CAP_IR: cap_ir   = 1'b1;
            ST_SH_IR:  sh_ir    = 1'b1;
            ST_UPD_IR: upd_ir   = 1'b1;
            ST_CAP_DR: cap_dr   = 1'b1;
            ST_SH_DR:  sh_dr    = 1'b1;
            ST_UPD_DR: upd_dr   = 1'b1;
            ST_IDLE, ST_SEL_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
            ST_SEL_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/jtc_ir_path.sv
module jtc_ir_path #(
    parameter int                IR_W   = 8,
    parameter logic [IR_W-1:0]   CAPT_V = 1,
    parameter logic [IR_W-1:0]   RST_V  = 0
) (
    input  logic            tck,
    input  logic            arst,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap,
    input  logic            sh,
    input  logic            upd,
    output logic            lsb,
    output logic [IR_W-1:0] code
);

    localparam int TOP = IR_W - 1;

    logic [IR_W-1:0] shreg;

    always_ff @(posedge tck or posedge arst) begin
        if (arst) begin
            shreg <= '0;
            code  <= RST_V;
        end else begin
            if (cap)     shreg <= CAPT_V;
            else if (sh) shreg <= {tdi, shreg[TOP:1]};
            if (upd)           code <= shreg;
            else if (in_reset) code <= RST_V;
        end
    end

    assign lsb = shreg[0];

endmodule

// File: rtl/jtc_dr_path.sv
module jtc_dr_path #(
    parameter int DR_W = 32
) (
    input  logic            tck,
    input  logic            arst,
    input  logic            tdi,
    input  logic            cap,
    input  logic            sh,
    input  logic            upd,
    input  logic [DR_W-1:0] held,
    output logic            lsb,
    output logic [DR_W-1:0] data
);

    localparam int TOP = DR_W - 1;

    logic [DR_W-1:0] shreg;

    always_ff @(posedge tck or posedge arst) begin
        if (arst) begin
            shreg <= '0;
            data  <= '0;
        end else begin
            if (cap)     shreg <= held;
            else if (sh) shreg <= {tdi, shreg[TOP:1]};
            if (upd)     data  <= shreg;
        end
    end

    assign lsb = shreg[0];

endmodule

// File: rtl/jtc_rb_latch.sv
module jtc_rb_latch #(
    parameter int DR_W = 32
) (
    input  logic            tck,
    input  logic            arst,
    input  logic [DR_W-1:0] word_in,
    input  logic            valid_in,
    output logic            taken,
    output logic [DR_W-1:0] held
);

    always_ff @(posedge tck or posedge arst) begin
        if (arst) begin
            held  <= '0;
            taken <= 1'b0;
        end else if (valid_in && !taken) begin
            held  <= word_in;
            taken <= 1'b1;
        end else if (!valid_in) begin
            taken <= 1'b0;
        end
    end

endmodule

// File: rtl/jtc_cmd_tap.sv
module jtc_cmd_tap
    import jtc_pkg::*;
#(
    parameter int IR_W = 8,
    parameter int DR_W = 32
) (
    input  logic            tck,
    input  logic            tms,
    input  logic            tdi,
    input  logic            arst,
    output logic            tdo_bit,
    output logic            tdo_drv,
    output logic [IR_W-1:0] cmd_code,
    output logic [DR_W-1:0] cmd_data,
    input  logic [DR_W-1:0] rd_word,
    input  logic            rd_valid,
    output logic            rd_taken
);

    localparam logic [IR_W-1:0] IR_CAPT = IR_W'(1);
    localparam logic [IR_W-1:0] IR_RST  = '0;

    tap_st_e         cur_st;
    logic            in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
    logic            ir_lsb, dr_lsb;
    logic [DR_W-1:0] rb_held;

    jtc_tap_fsm u_fsm (
        .tck      (tck),
        .arst     (arst),
        .tms      (tms),
        .st       (cur_st),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir),
        .cap_dr   (cap_dr),
        .sh_dr    (sh_dr),
        .upd_dr   (upd_dr)
    );

    jtc_ir_path #(.IR_W(IR_W), .CAPT_V(IR_CAPT), .RST_V(IR_RST)) u_ir (
        .tck      (tck),
        .arst     (arst),
        .tdi      (tdi),
        .in_reset (in_reset),
        .cap      (cap_ir),
        .sh       (sh_ir),
        .upd      (upd_ir),
        .lsb      (ir_lsb),
        .code     (cmd_code)
    );

    jtc_dr_path #(.DR_W(DR_W)) u_dr (
        .tck  (tck),
        .arst (arst),
        .tdi  (tdi),
        .cap  (cap_dr),
        .sh   (sh_dr),
        .upd  (upd_dr),
        .held (rb_held),
        .lsb  (dr_lsb),
        .data (cmd_data)
    );

    jtc_rb_latch #(.DR_W(DR_W)) u_rb (
        .tck      (tck),
        .arst     (arst),
        .word_in  (rd_word),
        .valid_in (rd_valid),
        .taken    (rd_taken),
        .held     (rb_held)
    );

    // Serial output: launched on the falling edge
    always_ff @(negedge tck or posedge arst) begin
        if (arst) begin
            tdo_bit <= 1'b0;
            tdo_drv <= 1'b0;
        end else begin
            tdo_drv <= sh_ir | sh_dr;
            tdo_bit <= sh_ir ? ir_lsb : (sh_dr ? dr_lsb : 1'b0);
        end
    end

endmodule

// File: rtl/jtc_cmd_tap_chk.sv
module jtc_cmd_tap_chk
    import jtc_pkg::*;
#(
    parameter int IR_W = 8,
    parameter int DR_W = 32
) (
    input logic            tck,
    input logic            arst,
    input tap_st_e         cur_st,
    input logic [IR_W-1:0] cmd_code,
    input logic [DR_W-1:0] cmd_data,
    input logic            rd_valid,
    input logic            rd_taken,
    input logic            tdo_drv
);

    // R1: reset holds the machine in Test-Logic-Reset
    always @(negedge tck) begin
        if (arst) begin
            a_r1_reset_state: assert (cur_st == ST_RESET && !tdo_drv && !rd_taken);
        end
    end

    a_r2_reset_clears_code: assert property (@(posedge tck) disable iff (arst)
        (cur_st == ST_RESET) |=> (cmd_code == '0));

    a_r3_code_only_on_update: assert property (@(posedge tck) disable iff (arst)
        (cur_st != ST_UPD_IR && cur_st != ST_RESET) |=> $stable(cmd_code));

    a_r4_data_only_on_update: assert property (@(posedge tck) disable iff (arst)
        (cur_st != ST_UPD_DR) |=> $stable(cmd_data));

    a_r6_drv_in_shift: assert property (@(posedge tck) disable iff (arst)
        tdo_drv == (cur_st == ST_SH_IR || cur_st == ST_SH_DR));

    a_r7_take_on_valid: assert property (@(posedge tck) disable iff (arst)
        (rd_valid && !rd_taken) |=> rd_taken);

    a_r7_hold_while_valid: assert property (@(posedge tck) disable iff (arst)
        (rd_valid && rd_taken) |=> rd_taken);

    a_r7_drop_on_idle: assert property (@(posedge tck) disable iff (arst)
        !rd_valid |=> !rd_taken);

endmodule

bind jtc_cmd_tap jtc_cmd_tap_chk #(.IR_W(IR_W), .DR_W(DR_W)) u_chk (
    .tck      (tck),
    .arst     (arst),
    .cur_st   (cur_st),
    .cmd_code (cmd_code),
    .cmd_data (cmd_data),
    .rd_valid (rd_valid),
    .rd_taken (rd_taken),
    .tdo_drv  (tdo_drv)
);

// File: tb/jtc_cmd_tap_tb.sv
module jtc_cmd_tap_tb;

    typedef struct {
        int          w;
        logic [31:0] v;
        string       tag;
    } exp_t;

    logic        tck = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        arst = 1'b1;
    logic        tdo_bit, tdo_drv, rd_taken;
    logic [7:0]  cmd_code;
    logic [31:0] cmd_data;
    logic [31:0] rd_word = '0;
    logic        rd_valid = 1'b0;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;
    exp_t exp_q[$];

    always #5 tck = ~tck;

    jtc_cmd_tap u_dut (
        .tck(tck), .tms(tms), .tdi(tdi), .arst(arst),
        .tdo_bit(tdo_bit), .tdo_drv(tdo_drv),
        .cmd_code(cmd_code), .cmd_data(cmd_data),
        .rd_word(rd_word), .rd_valid(rd_valid), .rd_taken(rd_taken)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one TCK cycle's inputs just after the falling edge
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
    endtask

    task automatic push(input int w, input logic [31:0] v, input string tag);
        exp_t e;
        e.w = w; e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: assembles TDO words while tdo_drv is high, compares on its fall
    int          mcnt = 0;
    logic [31:0] macc = '0;
    logic        neg_bit = 1'b0;
    logic        neg_drv = 1'b0;

    always @(negedge tck) begin
        #2;
        neg_bit = tdo_bit;
        neg_drv = tdo_drv;
        if (arst) begin
            mcnt = 0;
            macc = '0;
        end else if (tdo_drv) begin
            if (mcnt < 32) macc[mcnt] = tdo_bit;
            mcnt++;
        end else if (mcnt != 0) begin
            if (exp_q.size() == 0) begin
                check(0, "R3/R4 unexpected scan word", macc, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(mcnt == e.w && macc == e.v, e.tag, macc, e.v);
            end
            mcnt = 0;
            macc = '0;
        end
    end

    // R6: TDO must not move on the rising edge
    always @(posedge tck) begin
        #1;
        if (!arst && neg_drv && tdo_drv)
            check(tdo_bit == neg_bit, "R6 tdo changed on rising edge", 32'(tdo_bit), 32'(neg_bit));
    end

    task automatic scan_ir(input logic [7:0] code, input logic [7:0] old_code);
        push(8, 32'h01, "R3 captured IR value");
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 8; i++) step(i == 7, code[i]);
        step(1, 0);
        check(cmd_code == old_code, "R3 code before Update-IR", 32'(cmd_code), 32'(old_code));
        step(0, 0);
        step(0, 0);
        check(cmd_code == code, "R3 code after Update-IR", 32'(cmd_code), 32'(code));
    endtask

    task automatic scan_dr(input logic [31:0] din, input logic [31:0] exp_out,
                           input logic [31:0] old_data, input bit collide,
                           input logic [31:0] new_word);
        push(32, exp_out, collide ? "R8 capture takes previous word" : "R4 captured read-back word");
        step(1, 0); step(0, 0); step(0, 0);
        if (collide) begin
            rd_word  = new_word;
            rd_valid = 1'b1;
        end
        for (int i = 0; i < 32; i++) step(i == 31, din[i]);
        step(1, 0);
        check(cmd_data == old_data, "R4 data before Update-DR", cmd_data, old_data);
        step(0, 0);
        step(0, 0);
        check(cmd_data == din, "R4 data after Update-DR", cmd_data, din);
        if (collide) check(rd_taken == 1'b1, "R8 latch taken", 32'(rd_taken), 32'd1);
    endtask

    task automatic handshake(input logic [31:0] w);
        step(0, 0);
        rd_word  = w;
        rd_valid = 1'b1;
        step(0, 0);
        check(rd_taken == 1'b1, "R7 taken after valid", 32'(rd_taken), 32'd1);
        step(0, 0);
        check(rd_taken == 1'b1, "R7 taken held", 32'(rd_taken), 32'd1);
        rd_valid = 1'b0;
        step(0, 0);
        check(rd_taken == 1'b0, "R7 taken cleared", 32'(rd_taken), 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge tck);
        #1;
        check(tdo_drv == 0 && tdo_bit == 0, "R1 reset tdo", {30'd0, tdo_drv, tdo_bit}, '0);
        check(cmd_code == 0, "R1 reset code", 32'(cmd_code), '0);
        check(cmd_data == 0, "R1 reset data", cmd_data, '0);
        check(rd_taken == 0, "R1 reset taken", 32'(rd_taken), '0);
        @(negedge tck); #1;
        arst = 1'b0;
        step(0, 0);
        step(0, 0);

        handshake(32'hC3A5_0F96);
        scan_ir(8'h03, 8'h00);
        scan_dr(32'h1234_5678, 32'hC3A5_0F96, 32'h0, 0, '0);
        scan_ir(8'h0A, 8'h03);

        // R5: split scan with Pause-DR
        handshake(32'h8001_7FFE);
        push(16, 32'h0000_7FFE, "R5 first segment before pause");
        push(16, 32'h0000_8001, "R5 second segment after pause");
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 16; i++) step(i == 15, 1'(32'hDEAD_BEEF >> i));
        step(0, 0); step(0, 0); step(0, 0);
        check(cmd_data == 32'h1234_5678, "R5 data kept in pause", cmd_data, 32'h1234_5678);
        check(tdo_drv == 0, "R6 no drive in pause", 32'(tdo_drv), '0);
        step(1, 0); step(0, 0);
        for (int i = 16; i < 32; i++) step(i == 31, 1'(32'hDEAD_BEEF >> i));
        step(1, 0); step(0, 0); step(0, 0);
        check(cmd_data == 32'hDEAD_BEEF, "R5 data after resumed scan", cmd_data, 32'hDEAD_BEEF);

        // R8: latch edge coincides with Capture-DR
        scan_dr(32'h0F0F_1E1E, 32'h8001_7FFE, 32'hDEAD_BEEF, 1, 32'h5A5A_00FF);
        rd_valid = 1'b0;
        step(0, 0);
        step(0, 0);
        scan_dr(32'h7777_0001, 32'h5A5A_00FF, 32'h0F0F_1E1E, 0, '0);

        // R2: six TMS-high edges reach Test-Logic-Reset
        for (int i = 0; i < 6; i++) step(1, 0);
        check(cmd_code == 8'h00, "R2 code cleared in reset state", 32'(cmd_code), '0);
        check(cmd_data == 32'h7777_0001, "R2 data kept in reset state", cmd_data, 32'h7777_0001);
        step(0, 0);

        // R1: asynchronous reset in the middle of a data scan
        scan_ir(8'h04, 8'h00);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(0, 1);
        arst = 1'b1;
        #1;
        check(tdo_drv == 0, "R1 async reset drops drive", 32'(tdo_drv), '0);
        check(cmd_code == 0 && cmd_data == 0, "R1 async reset clears outputs",
              cmd_data | 32'(cmd_code), '0);
        step(1, 0); step(1, 0);
        arst = 1'b0;
        step(0, 0);
        step(0, 0);
        scan_dr(32'hA5A5_5A5A, 32'h0, 32'h0, 0, '0);

        step(0, 0); step(0, 0);
        check(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule